// File: doc/BRIEF.md
# L2 MAC table hash lookup

This block finds the forwarding entry for a MAC address and VLAN pair. It builds a 64-bit key with the MAC address in bits 63:16, zeros in bits 15:12 and the VID in bits 11:0. It folds that key into an 11-bit bucket number using one of two XOR hashes and then reads the four positions of that bucket from an external hashed SRAM. If none of them match, it reads a 64-entry fully associative CAM in index order. The first entry that is valid and matches both the MAC and the VID ends the search. The block reports whether it found a match, whether the match came from the CAM, the position or CAM index, the port and the bucket number.

A separate command word reads any single SRAM or CAM entry by index and returns its decoded fields. Both the lookup and the command share one read engine and one external table port. Each read takes two cycles: the address cycle, then the cycle in which the returned data is checked. A request is taken only while the engine is idle.

Top module: `l2_mac_lookup`

## Requirements
- R1: With `alt_hash_i` low, the bucket is the XOR of key slices 10:0, 21:11, 32:22, 43:33 and 54:44, and of slice 63:55 zero-extended to 11 bits.
- R2: With `alt_hash_i` high, the hash is modified before the fold. Slice 21:11 becomes {s[4:0],s[10:5]}, slice 43:33 becomes {s[5:0],s[10:6]} and slice 54:44 becomes {s[6:0],s[10:7]}. The other three slices are unchanged. The select is sampled when the lookup is accepted.
- R3: A lookup accepted at clock edge E reads SRAM address bucket*4+p for p = 0,1,2,3 in that order. Each address uses `mem_sel_o`=0 and is driven in the cycle after edge E+2p. There is one idle cycle between reads.
- R4: After four SRAM reads without a match, the CAM is read at indices 0 up to 63 in order with `mem_sel_o`=1. The CAM index sits in the low 6 bits of `mem_addr_o`.
- R5: Entry layout on `mem_rdata_i`: word0 is bits 31:0, word1 is bits 63:32 and word2 is bits 95:64. The VID is word0[11:0], the port is word0[16:12] and the static flag is word0[19]. The MAC is {word1[27:0], word2[31:12]} and the RVID is word2[11:0]. An entry is valid exactly when word0[31:17] is nonzero, so a set static flag alone makes it valid.
- R6: The first valid entry whose MAC and VID equal the request ends the search. An SRAM position takes precedence over the CAM, and a lower CAM index over a higher one. `res_valid_o` pulses for one cycle after edge E+2k, where k is the number of reads made. With the pulse come `res_hit_o`=1, `res_cam_o`, the position or index on `res_idx_o`, the port and the bucket.
- R7: When all 68 reads miss, the result pulses after edge E+136 with hit, CAM flag, index and port at zero and the bucket still reported.
- R8: Command word layout: bit 16 is execute, bit 15 is read, bits 14:13 are the table (0 = hash SRAM with a 13-bit index, 1 = CAM with a 6-bit index) and bits 12:0 are the index. An executing read written at edge E drives one read in the next cycle. It pulses `ent_done_o` after edge E+2, with the decoded fields of R5 on the `ent_*` outputs.
- R9: `cmd_stat_o` returns the stored command word. Bit 16 clears by itself when the read completes. A command word with bit 15 clear or a table code of 2 or 3 is stored with bit 16 already clear. It makes no read, no `ent_done_o` pulse and no change to the `ent_*` outputs.
- R10: While `busy_o` is high, lookups and command writes are ignored. When both arrive at an idle engine in the same cycle, the command is served and the lookup is dropped.
- R11: After reset, `busy_o`, `mem_rd_o`, `res_valid_o`, `ent_done_o` and `cmd_stat_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alt_hash_i | input | 1 | Selects the rotating hash |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_mac_i | input | 48 | MAC address to find |
| lkp_vid_i | input | 12 | VID to find |
| cmd_we_i | input | 1 | Command word write |
| cmd_wdata_i | input | 17 | Command word |
| mem_rd_o | output | 1 | Table read strobe |
| mem_sel_o | output | 1 | 0 = hash SRAM, 1 = CAM |
| mem_addr_o | output | 13 | Table address |
| mem_rdata_i | input | 96 | Entry returned the cycle after the read |
| busy_o | output | 1 | Engine active |
| cmd_stat_o | output | 17 | Stored command word |
| res_valid_o | output | 1 | Lookup result pulse |
| res_hit_o | output | 1 | Match found |
| res_cam_o | output | 1 | Match came from the CAM |
| res_idx_o | output | 6 | Bucket position or CAM index |
| res_port_o | output | 5 | Port of the matching entry |
| res_bucket_o | output | 11 | Bucket number used |
| ent_done_o | output | 1 | Command read complete |
| ent_valid_o | output | 1 | Decoded valid flag |
| ent_static_o | output | 1 | Decoded static flag |
| ent_port_o | output | 5 | Decoded port |
| ent_vid_o | output | 12 | Decoded VID |
| ent_rvid_o | output | 12 | Decoded RVID |
| ent_mac_o | output | 48 | Decoded MAC |

## Verification
The assertions rely on the table port returning the addressed entry exactly one cycle after `mem_rd_o`. They also rely on the tables not changing while a lookup is running. Under those conditions the sequences of read strobes, result pulses and command clears can be stated purely from the ports. The stimulus drives requests only on falling edges and loads the SRAM and CAM models between operations, never during one. It raises requests during a busy lookup only to show that they are ignored.

// File: rtl/l2_lookup_pkg.sv
package l2_lookup_pkg;
  parameter int MAC_W     = 48;
  parameter int VID_W     = 12;
  parameter int PORT_W    = 5;
  parameter int HASH_W    = 11;
  parameter int KEY_W     = 64;
  parameter int WAYS      = 4;
  parameter int CAM_DEPTH = 64;
  parameter int WORD_W    = 32;

  localparam int ENT_W   = 3 * WORD_W;
  localparam int POS_W   = $clog2(WAYS);
  localparam int IDX_W   = HASH_W + POS_W;
  localparam int CAM_W   = $clog2(CAM_DEPTH);
  localparam int CNT_W   = (CAM_W > POS_W) ? CAM_W : POS_W;
  localparam int PAD_W   = KEY_W - MAC_W - VID_W;
  localparam int CMD_W   = 17;
  localparam int CMD_EXEC = 16;
  localparam int CMD_RD   = 15;
  localparam int CMD_TBL  = 13;
  localparam int VALID_LO = 17;

  localparam logic [1:0] TBL_HASH = 2'd0;
  localparam logic [1:0] TBL_CAM  = 2'd1;

  typedef struct packed {
    logic              valid;
    logic              is_static;
    logic [PORT_W-1:0] port;
    logic [VID_W-1:0]  vid;
    logic [VID_W-1:0]  rvid;
    logic [MAC_W-1:0]  mac;
  } entry_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_CHK} state_t;
endpackage

// File: rtl/l2_key_hash.sv
module l2_key_hash
  import l2_lookup_pkg::*;
(
  input  logic [KEY_W-1:0]  key_i,
  input  logic              alt_i,
  output logic [HASH_W-1:0] hash_o
);
  localparam int N_SLICE = (KEY_W + HASH_W - 1) / HASH_W;

  logic [HASH_W-1:0] slice [N_SLICE];
  logic [HASH_W-1:0] rot   [N_SLICE];

  for (genvar g = 0; g < N_SLICE; g++) begin : g_slice
    // rotate-left amount applied in the alternate mode
    localparam int R = (g == 1) ? 6 : (g == 3) ? 5 : (g == 4) ? 4 : 0;
    assign slice[g] = HASH_W'(key_i >> (g * HASH_W));
    if (R == 0) begin : g_plain
      assign rot[g] = slice[g];
    end else begin : g_rot
      assign rot[g] = {slice[g][HASH_W-1-R:0], slice[g][HASH_W-1:HASH_W-R]};
    end
  end

  always_comb begin
    hash_o = '0;
    for (int i = 0; i < N_SLICE; i++) begin
      hash_o = hash_o ^ (alt_i ? rot[i] : slice[i]);
    end
  end
endmodule

// File: rtl/l2_entry_decode.sv
module l2_entry_decode
  import l2_lookup_pkg::*;
(
  input  logic [ENT_W-1:0] word_i,
  output entry_t           ent_o
);
  logic [WORD_W-1:0] w0, w1, w2;
  logic              unused_bits;

  assign w0 = word_i[0*WORD_W +: WORD_W];
  assign w1 = word_i[1*WORD_W +: WORD_W];
  assign w2 = word_i[2*WORD_W +: WORD_W];

  assign ent_o.valid     = |w0[WORD_W-1:VALID_LO];
  assign ent_o.is_static = w0[19];
  assign ent_o.port      = w0[VID_W +: PORT_W];
  assign ent_o.vid       = w0[VID_W-1:0];
  assign ent_o.rvid      = w2[VID_W-1:0];
  assign ent_o.mac       = {w1[27:0], w2[WORD_W-1:VID_W]};

  assign unused_bits = ^{w0[18], w1[WORD_W-1:28]};
endmodule

// File: rtl/l2_lookup_ctrl.sv
module l2_lookup_ctrl
  import l2_lookup_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [MAC_W-1:0]  lkp_mac_i,
  input  logic [VID_W-1:0]  lkp_vid_i,
  input  logic [HASH_W-1:0] lkp_hash_i,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_wdata_i,
  input  entry_t            ent_i,
  output logic              mem_rd_o,
  output logic              mem_sel_o,
  output logic [IDX_W-1:0]  mem_addr_o,
  output logic              busy_o,
  output logic [CMD_W-1:0]  cmd_stat_o,
  output logic              res_valid_o,
  output logic              res_hit_o,
  output logic              res_cam_o,
  output logic [CNT_W-1:0]  res_idx_o,
  output logic [PORT_W-1:0] res_port_o,
  output logic [HASH_W-1:0] res_bucket_o,
  output logic              ent_done_o,
  output entry_t            ent_o
);
  localparam logic [CNT_W-1:0] WAY_LAST = CNT_W'(WAYS - 1);
  localparam logic [CNT_W-1:0] CAM_LAST = CNT_W'(CAM_DEPTH - 1);

  state_t            state_q;
  logic              is_cmd_q, cam_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HASH_W-1:0] hash_q;
  logic [MAC_W-1:0]  mac_q;
  logic [VID_W-1:0]  vid_q;
  logic [CMD_W-1:0]  cmd_q;

  logic [1:0] wr_tbl, cmd_tbl;
  logic       cmd_ok, hit_now, last_now;

  assign wr_tbl  = cmd_wdata_i[CMD_TBL +: 2];
  assign cmd_tbl = cmd_q[CMD_TBL +: 2];
  assign cmd_ok  = cmd_wdata_i[CMD_EXEC] & cmd_wdata_i[CMD_RD] &
                   ((wr_tbl == TBL_HASH) | (wr_tbl == TBL_CAM));

  assign hit_now  = ent_i.valid && (ent_i.mac == mac_q) && (ent_i.vid == vid_q);
  assign last_now = cam_q ? (cnt_q == CAM_LAST) : (cnt_q == WAY_LAST);

  always_comb begin
    mem_rd_o = (state_q == ST_RD);
    if (is_cmd_q) begin
      mem_sel_o  = (cmd_tbl == TBL_CAM);
      mem_addr_o = mem_sel_o ? IDX_W'(cmd_q[CAM_W-1:0]) : cmd_q[IDX_W-1:0];
    end else begin
      mem_sel_o  = cam_q;
      mem_addr_o = cam_q ? IDX_W'(cnt_q) : {hash_q, cnt_q[POS_W-1:0]};
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign cmd_stat_o = cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      is_cmd_q     <= 1'b0;
      cam_q        <= 1'b0;
      cnt_q        <= '0;
      hash_q       <= '0;
      mac_q        <= '0;
      vid_q        <= '0;
      cmd_q        <= '0;
      res_valid_o  <= 1'b0;
      res_hit_o    <= 1'b0;
      res_cam_o    <= 1'b0;
      res_idx_o    <= '0;
      res_port_o   <= '0;
      res_bucket_o <= '0;
      ent_done_o   <= 1'b0;
      ent_o        <= '0;
    end else begin
      res_valid_o <= 1'b0;
      ent_done_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_we_i) begin
            cmd_q <= cmd_wdata_i;
            if (cmd_ok) begin
              is_cmd_q <= 1'b1;
              state_q  <= ST_RD;
            end else begin
              cmd_q[CMD_EXEC] <= 1'b0;
            end
          end else if (lkp_valid_i) begin
            is_cmd_q <= 1'b0;
            cam_q    <= 1'b0;
            cnt_q    <= '0;
            hash_q   <= lkp_hash_i;
            mac_q    <= lkp_mac_i;
            vid_q    <= lkp_vid_i;
            state_q  <= ST_RD;
          end
        end
        ST_RD: state_q <= ST_CHK;
        ST_CHK: begin
          if (is_cmd_q) begin
            ent_o           <= ent_i;
            ent_done_o      <= 1'b1;
            cmd_q[CMD_EXEC] <= 1'b0;
            state_q         <= ST_IDLE;
          end else if (hit_now) begin
            res_valid_o  <= 1'b1;
            res_hit_o    <= 1'b1;
            res_cam_o    <= cam_q;
            res_idx_o    <= cnt_q;
            res_port_o   <= ent_i.port;
            res_bucket_o <= hash_q;
            state_q      <= ST_IDLE;
          end else if (last_now && !cam_q) begin
            cam_q   <= 1'b1;
            cnt_q   <= '0;
            state_q <= ST_RD;
          end else if (last_now) begin
            res_valid_o  <= 1'b1;
            res_hit_o    <= 1'b0;
            res_cam_o    <= 1'b0;
            res_idx_o    <= '0;
            res_port_o   <= '0;
            res_bucket_o <= hash_q;
            state_q      <= ST_IDLE;
          end else begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= ST_RD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/l2_mac_lookup.sv
module l2_mac_lookup
  import l2_lookup_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alt_hash_i,
  input  logic              lkp_valid_i,
  input  logic [MAC_W-1:0]  lkp_mac_i,
  input  logic [VID_W-1:0]  lkp_vid_i,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_wdata_i,
  output logic              mem_rd_o,
  output logic              mem_sel_o,
  output logic [IDX_W-1:0]  mem_addr_o,
  input  logic [ENT_W-1:0]  mem_rdata_i,
  output logic              busy_o,
  output logic [CMD_W-1:0]  cmd_stat_o,
  output logic              res_valid_o,
  output logic              res_hit_o,
  output logic              res_cam_o,
  output logic [CNT_W-1:0]  res_idx_o,
  output logic [PORT_W-1:0] res_port_o,
  output logic [HASH_W-1:0] res_bucket_o,
  output logic              ent_done_o,
  output logic              ent_valid_o,
  output logic              ent_static_o,
  output logic [PORT_W-1:0] ent_port_o,
  output logic [VID_W-1:0]  ent_vid_o,
  output logic [VID_W-1:0]  ent_rvid_o,
  output logic [MAC_W-1:0]  ent_mac_o
);
  logic [KEY_W-1:0]  key;
  logic [HASH_W-1:0] hash;
  entry_t            rd_ent, ent_q;

  assign key = {lkp_mac_i, {PAD_W{1'b0}}, lkp_vid_i};

  l2_key_hash u_hash (
    .key_i  (key),
    .alt_i  (alt_hash_i),
    .hash_o (hash)
  );

  l2_entry_decode u_dec (
    .word_i (mem_rdata_i),
    .ent_o  (rd_ent)
  );

  l2_lookup_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lkp_valid_i  (lkp_valid_i),
    .lkp_mac_i    (lkp_mac_i),
    .lkp_vid_i    (lkp_vid_i),
    .lkp_hash_i   (hash),
    .cmd_we_i     (cmd_we_i),
    .cmd_wdata_i  (cmd_wdata_i),
    .ent_i        (rd_ent),
    .mem_rd_o     (mem_rd_o),
    .mem_sel_o    (mem_sel_o),
    .mem_addr_o   (mem_addr_o),
    .busy_o       (busy_o),
    .cmd_stat_o   (cmd_stat_o),
    .res_valid_o  (res_valid_o),
    .res_hit_o    (res_hit_o),
    .res_cam_o    (res_cam_o),
    .res_idx_o    (res_idx_o),
    .res_port_o   (res_port_o),
    .res_bucket_o (res_bucket_o),
    .ent_done_o   (ent_done_o),
    .ent_o        (ent_q)
  );

  assign ent_valid_o  = ent_q.valid;
  assign ent_static_o = ent_q.is_static;
  assign ent_port_o   = ent_q.port;
  assign ent_vid_o    = ent_q.vid;
  assign ent_rvid_o   = ent_q.rvid;
  assign ent_mac_o    = ent_q.mac;
endmodule

// File: rtl/l2_mac_lookup_chk.sv
module l2_mac_lookup_chk
  import l2_lookup_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_rd_o,
  input logic              mem_sel_o,
  input logic [IDX_W-1:0]  mem_addr_o,
  input logic              busy_o,
  input logic [CMD_W-1:0]  cmd_stat_o,
  input logic              res_valid_o,
  input logic              res_hit_o,
  input logic              res_cam_o,
  input logic [CNT_W-1:0]  res_idx_o,
  input logic [PORT_W-1:0] res_port_o,
  input logic              ent_done_o
);
  p_cam_addr_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && mem_sel_o |-> mem_addr_o < IDX_W'(CAM_DEPTH));

  p_read_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  p_read_when_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> busy_o);

  p_res_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);

  p_res_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> !busy_o && $past(mem_rd_o, 2));

  p_way_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_hit_o && !res_cam_o |-> res_idx_o < CNT_W'(WAYS));

  p_miss_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_hit_o |-> res_idx_o == '0 && res_port_o == '0 && !res_cam_o);

  p_ent_after_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_done_o |-> $past(mem_rd_o, 2) && !busy_o);

  p_exec_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_done_o |-> !cmd_stat_o[CMD_EXEC] && $past(cmd_stat_o[CMD_EXEC]));

  p_exec_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_stat_o[CMD_EXEC] |-> busy_o);
endmodule

bind l2_mac_lookup l2_mac_lookup_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_rd_o    (mem_rd_o),
  .mem_sel_o   (mem_sel_o),
  .mem_addr_o  (mem_addr_o),
  .busy_o      (busy_o),
  .cmd_stat_o  (cmd_stat_o),
  .res_valid_o (res_valid_o),
  .res_hit_o   (res_hit_o),
  .res_cam_o   (res_cam_o),
  .res_idx_o   (res_idx_o),
  .res_port_o  (res_port_o),
  .ent_done_o  (ent_done_o)
);

// File: tb/sim_l2_mac_lookup.sv
`timescale 1ns/1ps
module sim_l2_mac_lookup;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alt_hash_i = 1'b0;
  logic        lkp_valid_i = 1'b0;
  logic [47:0] lkp_mac_i = '0;
  logic [11:0] lkp_vid_i = '0;
  logic        cmd_we_i = 1'b0;
  logic [16:0] cmd_wdata_i = '0;
  logic        mem_rd_o, mem_sel_o;
  logic [12:0] mem_addr_o;
  logic [95:0] mem_rdata_i = '0;
  logic        busy_o;
  logic [16:0] cmd_stat_o;
  logic        res_valid_o, res_hit_o, res_cam_o;
  logic [5:0]  res_idx_o;
  logic [4:0]  res_port_o;
  logic [10:0] res_bucket_o;
  logic        ent_done_o, ent_valid_o, ent_static_o;
  logic [4:0]  ent_port_o;
  logic [11:0] ent_vid_o, ent_rvid_o;
  logic [47:0] ent_mac_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [95:0] sram [int];
  logic [95:0] cam_mem [64];

  always #4 clk_i = ~clk_i;

  l2_mac_lookup u0 (.*);

  function automatic logic [95:0] sram_rd(input int a);
    return sram.exists(a) ? sram[a] : 96'd0;
  endfunction

  always @(posedge clk_i)
    if (mem_rd_o) mem_rdata_i <= mem_sel_o ? cam_mem[mem_addr_o[5:0]] : sram_rd(int'(mem_addr_o));

  function automatic logic [95:0] mk(input logic [47:0] mac, input logic [11:0] vid,
                                     input logic [4:0] port, input bit st, input bit v,
                                     input logic [11:0] rvid);
    logic [31:0] w0, w1, w2;
    w0 = {12'd0, st, 1'b0, v, port, vid};
    w1 = {4'd0, mac[47:20]};
    w2 = {mac[19:0], rvid};
    return {w2, w1, w0};
  endfunction

  function automatic int ref_hash(input logic [63:0] k, input bit alt);
    int h = 0;
    for (int i = 0; i < 6; i++) begin
      int s = int'((k >> (11 * i)) & 64'h7ff);
      int r = 0;
      if (alt) r = (i == 1) ? 6 : (i == 3) ? 5 : (i == 4) ? 4 : 0;
      if (r != 0) s = ((s << r) | (s >> (11 - r))) & 'h7ff;
      h = h ^ s;
    end
    return h;
  endfunction

  task automatic ref_scan(input logic [47:0] mac, input logic [11:0] vid, input bit alt,
                          output int h, output int n, output bit hit, output bit cam,
                          output int idx, output int port);
    logic [95:0] e;
    h = ref_hash({mac, 4'h0, vid}, alt);
    n = 68; hit = 0; cam = 0; idx = 0; port = 0;
    for (int i = 0; i < 68; i++) begin
      e = (i < 4) ? sram_rd(h * 4 + i) : cam_mem[i - 4];
      if (e[31:17] != 0 && {e[59:32], e[95:76]} == mac && e[11:0] == vid) begin
        hit = 1; cam = (i >= 4); idx = (i < 4) ? i : i - 4; port = int'(e[16:12]); n = i + 1;
        break;
      end
    end
  endtask

  task automatic chk(input bit ok, input string req, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic run_lookup(input logic [47:0] mac, input logic [11:0] vid, input bit alt,
                            input bit poke, input string req);
    int h, n, eidx, eport;
    bit ehit, ecam, bad;
    logic [16:0] stat0;
    string why;
    ref_scan(mac, vid, alt, h, n, ehit, ecam, eidx, eport);
    stat0 = cmd_stat_o;
    bad = 0; why = "";
    @(negedge clk_i);
    lkp_valid_i = 1; lkp_mac_i = mac; lkp_vid_i = vid; alt_hash_i = alt;
    @(negedge clk_i);
    lkp_valid_i = 0;
    for (int c = 0; c < 2 * n; c++) begin
      int rd = c / 2;
      int ea = (rd < 4) ? h * 4 + rd : rd - 4;
      if (res_valid_o !== 1'b0 || busy_o !== 1'b1) begin
        if (!bad) why = $sformatf("cycle %0d res_valid=%b busy=%b exp 0/1", c, res_valid_o, busy_o);
        bad = 1;
      end
      if (c % 2 == 0) begin
        if (mem_rd_o !== 1'b1 || mem_sel_o !== (rd >= 4) || mem_addr_o !== 13'(ea)) begin
          if (!bad) why = $sformatf("read %0d rd=%b sel=%b addr=%0d exp sel=%b addr=%0d",
                                    rd, mem_rd_o, mem_sel_o, mem_addr_o, rd >= 4, ea);
          bad = 1;
        end
      end else if (mem_rd_o !== 1'b0) begin
        if (!bad) why = $sformatf("cycle %0d mem_rd=1 exp 0", c);
        bad = 1;
      end
      if (poke && c == 3) begin
        lkp_valid_i = 1; lkp_mac_i = 48'hAAAA; lkp_vid_i = 12'd1;
        cmd_we_i = 1; cmd_wdata_i = 17'h18000;
      end
      if (poke && c == 4) begin
        lkp_valid_i = 0; cmd_we_i = 0;
      end
      @(negedge clk_i);
    end
    chk(!bad, req, why);
    chk(res_valid_o === 1'b1 && res_hit_o === ehit && res_cam_o === ecam &&
        res_idx_o === 6'(eidx) && res_port_o === 5'(eport) && res_bucket_o === 11'(h), req,
        $sformatf("result v=%b hit=%b cam=%b idx=%0d port=%0d bkt=%h exp 1 %b %b %0d %0d %h",
                  res_valid_o, res_hit_o, res_cam_o, res_idx_o, res_port_o, res_bucket_o,
                  ehit, ecam, eidx, eport, h));
    if (poke)
      chk(cmd_stat_o === stat0, "R10", $sformatf("cmd_stat=%h exp %h", cmd_stat_o, stat0));
  endtask

  task automatic run_cmd(input logic [16:0] w, input bit exec, input logic [95:0] ew,
                         input string req);
    logic [47:0] m0; logic [11:0] v0, r0; logic [4:0] p0; logic s0, va0;
    bit bad;
    m0 = ent_mac_o; v0 = ent_vid_o; r0 = ent_rvid_o; p0 = ent_port_o; s0 = ent_static_o;
    va0 = ent_valid_o;
    @(negedge clk_i);
    cmd_we_i = 1; cmd_wdata_i = w;
    @(negedge clk_i);
    cmd_we_i = 0;
    if (exec) begin
      chk(cmd_stat_o === w && mem_rd_o === 1'b1 && mem_sel_o === (w[14:13] == 2'd1) &&
          mem_addr_o === ((w[14:13] == 2'd1) ? 13'(w[5:0]) : w[12:0]), req,
          $sformatf("issue stat=%h rd=%b sel=%b addr=%h exp stat=%h", cmd_stat_o, mem_rd_o,
                    mem_sel_o, mem_addr_o, w));
      @(negedge clk_i);
      chk(ent_done_o === 1'b0, req, $sformatf("early ent_done=%b exp 0", ent_done_o));
      @(negedge clk_i);
      chk(ent_done_o === 1'b1 && cmd_stat_o === (w & 17'h0FFFF) &&
          ent_mac_o === {ew[59:32], ew[95:76]} && ent_vid_o === ew[11:0] &&
          ent_rvid_o === ew[75:64] && ent_port_o === ew[16:12] &&
          ent_static_o === ew[19] && ent_valid_o === (ew[31:17] != 0), req,
          $sformatf("done=%b stat=%h mac=%h vid=%h rvid=%h port=%0d st=%b v=%b exp word %h",
                    ent_done_o, cmd_stat_o, ent_mac_o, ent_vid_o, ent_rvid_o, ent_port_o,
                    ent_static_o, ent_valid_o, ew));
    end else begin
      chk(cmd_stat_o === (w & 17'h0FFFF), req,
          $sformatf("stored stat=%h exp %h", cmd_stat_o, w & 17'h0FFFF));
      bad = 0;
      for (int c = 0; c < 5; c++) begin
        if (mem_rd_o !== 1'b0 || ent_done_o !== 1'b0 || busy_o !== 1'b0) bad = 1;
        @(negedge clk_i);
      end
      chk(!bad && ent_mac_o === m0 && ent_vid_o === v0 && ent_rvid_o === r0 &&
          ent_port_o === p0 && ent_static_o === s0 && ent_valid_o === va0, req,
          $sformatf("dropped cmd activity=%b mac=%h exp %h", bad, ent_mac_o, m0));
    end
  endtask

  localparam logic [47:0] MAC_A = 48'h0012_3456_789A;
  localparam logic [47:0] MAC_B = 48'h02AB_CDEF_0101;
  localparam logic [47:0] MAC_D = 48'h7C00_1F2E_3D4C;

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int ha, hd;
    bit ok;
    for (int i = 0; i < 64; i++) cam_mem[i] = '0;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk(busy_o === 0 && mem_rd_o === 0 && res_valid_o === 0 && ent_done_o === 0 &&
        cmd_stat_o === 0, "R11",
        $sformatf("busy=%b rd=%b res=%b done=%b stat=%h exp all 0", busy_o, mem_rd_o,
                  res_valid_o, ent_done_o, cmd_stat_o));
    rst_ni = 1;
    @(negedge clk_i);

    // R7 full miss on empty tables, R1 plain hash
    run_lookup(MAC_A, 12'h064, 0, 0, "R7");
    run_lookup(48'hFFFF_FFFF_FFFF, 12'hFFF, 0, 0, "R1");
    // R2 alternate hash on a miss
    run_lookup(48'hFFFF_FFFF_FFFF, 12'hFFF, 1, 0, "R2");
    run_lookup(48'h8421_0842_1084, 12'h210, 1, 0, "R2");

    // load SRAM bucket of key A (plain) and CAM
    ha = ref_hash({MAC_A, 4'h0, 12'h064}, 0);
    sram[ha * 4 + 0] = mk(MAC_A, 12'h064, 5'd4, 0, 0, 12'h000);
    sram[ha * 4 + 1] = mk(MAC_A, 12'h065, 5'd3, 0, 1, 12'h000);
    sram[ha * 4 + 2] = mk(MAC_A, 12'h064, 5'd7, 0, 1, 12'h123);
    cam_mem[3] = mk(MAC_A, 12'h064, 5'd9, 0, 1, 12'h000);
    cam_mem[5] = mk(MAC_B, 12'h005, 5'd1, 1, 0, 12'h0AB);
    cam_mem[9] = mk(MAC_B, 12'h005, 5'd2, 0, 1, 12'h000);
    hd = ref_hash({MAC_D, 4'h0, 12'h321}, 1);
    sram[hd * 4 + 3] = mk(MAC_D, 12'h321, 5'd17, 1, 1, 12'h777);

    // R5 invalid pos 0 skipped, wrong VID pos 1 skipped; R3/R6 hit at pos 2 before CAM
    run_lookup(MAC_A, 12'h064, 0, 0, "R6");
    // R2 alternate bucket differs: CAM index 3 found
    run_lookup(MAC_A, 12'h064, 1, 0, "R4");
    // R5 static-only entry counts as valid; R6 lower CAM index wins
    run_lookup(MAC_B, 12'h005, 0, 0, "R5");
    // R3 last bucket position in alternate mode
    run_lookup(MAC_D, 12'h321, 1, 0, "R3");
    // R10 requests during busy ignored
    run_lookup(48'h1111_2222_3333, 12'h444, 0, 1, "R10");

    // R8 command reads
    run_cmd(17'h18000 | 17'(ha * 4 + 2), 1, sram[ha * 4 + 2], "R8");
    run_cmd(17'h1A000 | 17'd5, 1, cam_mem[5], "R8");
    run_cmd(17'h18000 | 17'(hd * 4 + 3), 1, sram[hd * 4 + 3], "R8");
    // R9 dropped commands: read clear, table 2, table 3, no execute
    run_cmd(17'h10000 | 17'(ha * 4 + 1), 0, '0, "R9");
    run_cmd(17'h1C000 | 17'd2, 0, '0, "R9");
    run_cmd(17'h1E000, 0, '0, "R9");
    run_cmd(17'h08123, 0, '0, "R9");

    // R10 command wins over a simultaneous lookup
    @(negedge clk_i);
    cmd_we_i = 1; cmd_wdata_i = 17'h1A000 | 17'd9;
    lkp_valid_i = 1; lkp_mac_i = MAC_A; lkp_vid_i = 12'h064; alt_hash_i = 0;
    @(negedge clk_i);
    cmd_we_i = 0; lkp_valid_i = 0;
    ok = (mem_sel_o === 1'b1 && mem_addr_o === 13'd9);
    @(negedge clk_i);
    @(negedge clk_i);
    ok = ok && ent_done_o === 1'b1 && ent_port_o === 5'd2;
    for (int c = 0; c < 6; c++) begin
      if (res_valid_o !== 1'b0 || busy_o !== 1'b0) ok = 0;
      @(negedge clk_i);
    end
    chk(ok, "R10", $sformatf("priority: ent_port=%0d busy=%b exp CAM 9 port 2, lookup dropped",
                             ent_port_o, busy_o));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule